// File: doc/BRIEF.md
# Configurable SPI Master/Slave Shift Engine

This block moves one 8-bit word over a three-wire serial link (clock, data out, data in). A processor programs it through two byte-wide registers. The control register chooses master or slave operation, the master clock divide ratio, the clock edge used for launching and sampling, and the transmit and receive bit orders, which are set separately. The data register takes the byte to send and returns the last byte received.

In master mode the block drives the serial clock, derived from the system clock by a power-of-two divider. In slave mode it follows a serial clock from outside, which passes through a two-flop synchronizer before edge detection. Setting the start bit launches a transfer. The start bit stays set until the eighth bit has been sampled. The received word then moves into the receive buffer, and a read-buffer-full flag is raised until software reads the data register.

Top module: `spi_eng`

## Requirements
- R1: Control register (address 0) fields: bit0 start/busy, bit1 transmit order, bit2 receive order, bits5:3 mode code, bit6 edge select, bit7 receive-full flag. It reads 0x00 after reset. While idle, a write stores bits 6:1 and they read back unchanged.
- R2: Mode codes 0 to 4 select master mode. `sck_oe` is 1, and the SCK period is 2^(code+1) system clocks (divide by 2, 4, 8, 16 or 32).
- R3: Mode code 5 selects slave mode. `sck_oe` is 0, and data launch and sampling follow edges of `sck_i` after a two-flop synchronizer.
- R4: Mode codes 6 and 7 are invalid. A start request written with one of them is ignored: the start bit reads 0 and SCK does not toggle.
- R5: Transmit order bit 0 sends bit 7 first. Transmit order bit 1 sends bit 0 first.
- R6: Receive order bit 0 places the first received bit in bit 7. Receive order bit 1 places it in bit 0. This holds for any setting of the transmit order bit.
- R7: Edge select 0 gives SCK idle low, launch on the rising edge and sampling on the falling edge. Edge select 1 gives SCK idle high, launch on the falling edge and sampling on the rising edge. `sdo` changes only on a launch edge.
- R8: After a start, bit0 reads 1 until the eighth sample. In that cycle bit0 clears, the received byte enters the receive buffer (address 1), and the full flag sets.
- R9: A read of address 1 with `reg_rd` clears the full flag. If a transfer completes in the same cycle as that read, the flag stays set and the buffer holds the new byte.
- R10: While a transfer runs, writes to either register are ignored. Bit 7 of the control register cannot be written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effect on address 1) |
| reg_addr | input | 1 | 0 = control, 1 = data |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| sck_i | input | 1 | External serial clock (slave mode) |
| sck_o | output | 1 | Serial clock driven in master mode |
| sck_oe | output | 1 | Serial clock output enable |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |

## Verification
Two functions can hit the same clock edge: the eighth sample sets the receive-full flag, and a software read of the data register clears it. The bench provokes this in master mode with a divide ratio of 2. A previous byte is left unread, a new transfer starts, and the read strobe is placed exactly on the sixteenth SCK toggle, counted from the edge that took the start write. The outcome passes only if the read returns the old byte while the flag afterwards still shows set and the buffer holds the new byte.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;

  localparam int unsigned MODE_W = 3;
  localparam int unsigned MASTER_CODES = 5;
  localparam logic [MODE_W-1:0] MODE_LAST_MASTER = 3'd4;
  localparam logic [MODE_W-1:0] MODE_SLAVE = 3'd5;

  // control register bit positions (software decodes these)
  localparam int unsigned CB_START = 0;
  localparam int unsigned CB_TXORD = 1;
  localparam int unsigned CB_RXORD = 2;
  localparam int unsigned CB_MODE  = 3;
  localparam int unsigned CB_EDGE  = 6;
  localparam int unsigned CB_FULL  = 7;

  typedef struct packed {
    logic              edge_sel;
    logic [MODE_W-1:0] mode;
    logic              rx_lsb;
    logic              tx_lsb;
  } cfg_t;

  function automatic logic mode_is_master(input logic [MODE_W-1:0] m);
    return m <= MODE_LAST_MASTER;
  endfunction

  function automatic logic mode_is_valid(input logic [MODE_W-1:0] m);
    return (m <= MODE_LAST_MASTER) || (m == MODE_SLAVE);
  endfunction

endpackage

// File: rtl/spi_eng_sck.sv
module spi_eng_sck
  import spi_eng_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned DIV_W       = MASTER_CODES
) (
  input  logic clk,
  input  logic rst_n,
  input  logic busy,
  input  cfg_t cfg,
  input  logic idle_lvl,
  input  logic sck_in,
  output logic sck_out,
  output logic launch,
  output logic sample
);

  logic [DIV_W-1:0] div_q, div_d, lim;
  logic             sck_q, sck_d;
  logic             prev_q;
  logic [SYNC_STAGES-1:0] sync_q;
  logic             master, tick, s_now, s_rise, s_fall;
  logic             m_launch, m_sample, e_launch, e_sample;

  assign master = mode_is_master(cfg.mode);
  assign lim    = ({{(DIV_W-1){1'b0}}, 1'b1} << cfg.mode) - {{(DIV_W-1){1'b0}}, 1'b1};
  assign tick   = busy & master & (div_q == lim);

  always_comb begin
    div_d = div_q;
    sck_d = sck_q;
    if (!busy) begin
      div_d = '0;
      sck_d = idle_lvl;
    end else if (master) begin
      if (tick) begin
        div_d = '0;
        sck_d = ~sck_q;
      end else begin
        div_d = div_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      sck_q <= 1'b0;
    end else begin
      div_q <= div_d;
      sck_q <= sck_d;
    end
  end

  // external clock synchronizer chain
  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[g] <= 1'b0;
        else if (g == 0) sync_q[g] <= sck_in;
        else sync_q[g] <= sync_q[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign s_now = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= s_now;
  end

  assign s_rise   = s_now & ~prev_q;
  assign s_fall   = ~s_now & prev_q;
  assign m_launch = tick & (sck_q == cfg.edge_sel);
  assign m_sample = tick & (sck_q != cfg.edge_sel);
  assign e_launch = busy & (cfg.edge_sel ? s_fall : s_rise);
  assign e_sample = busy & (cfg.edge_sel ? s_rise : s_fall);

  assign launch  = master ? m_launch : e_launch;
  assign sample  = master ? m_sample : e_sample;
  assign sck_out = sck_q;

endmodule

// File: rtl/spi_eng_shift.sv
module spi_eng_shift #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] load_val,
  input  logic          launch,
  input  logic          sample,
  input  logic          tx_lsb,
  input  logic          rx_lsb,
  input  logic          sdi,
  output logic          sdo,
  output logic          last,
  output logic [DW-1:0] rx_next
);

  localparam int unsigned CNT_W = $clog2(DW);

  logic [DW-1:0]    tx_q, tx_d, rx_q, rx_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             first_q, first_d;

  assign rx_next = rx_lsb ? {sdi, rx_q[DW-1:1]} : {rx_q[DW-2:0], sdi};
  assign last    = sample & (cnt_q == CNT_W'(DW-1));
  assign sdo     = tx_lsb ? tx_q[0] : tx_q[DW-1];

  always_comb begin
    tx_d    = tx_q;
    rx_d    = rx_q;
    cnt_d   = cnt_q;
    first_d = first_q;
    if (load) begin
      tx_d    = load_val;
      rx_d    = '0;
      cnt_d   = '0;
      first_d = 1'b1;
    end else begin
      if (launch) begin
        first_d = 1'b0;
        if (!first_q) tx_d = tx_lsb ? {1'b0, tx_q[DW-1:1]} : {tx_q[DW-2:0], 1'b0};
      end
      if (sample) begin
        rx_d  = rx_next;
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q    <= '0;
      rx_q    <= '0;
      cnt_q   <= '0;
      first_q <= 1'b0;
    end else begin
      tx_q    <= tx_d;
      rx_q    <= rx_d;
      cnt_q   <= cnt_d;
      first_q <= first_d;
    end
  end

endmodule

// File: rtl/spi_eng.sv
module spi_eng
  import spi_eng_pkg::*;
#(
  parameter int unsigned DW          = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic          reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          sck_i,
  output logic          sck_o,
  output logic          sck_oe,
  output logic          sdo,
  input  logic          sdi
);

  localparam int unsigned DIV_W = MASTER_CODES;

  logic          rst_meta_q, rst_sync_q, srst_n;
  cfg_t          cfg_q, cfg_d, cfg_wr;
  logic          busy_q, busy_d, full_q, full_d;
  logic [DW-1:0] txd_q, txd_d, rxb_q, rxb_d, rx_next;
  logic          wr_ctrl, wr_data, rd_data, start_pulse;
  logic          launch, sample, last;

  // reset: asserted asynchronously, released on clk
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end
  assign srst_n = rst_sync_q;

  assign wr_ctrl = reg_wr & ~reg_addr;
  assign wr_data = reg_wr &  reg_addr;
  assign rd_data = reg_rd &  reg_addr;

  assign cfg_wr = '{edge_sel: reg_wdata[CB_EDGE],
                    mode:     reg_wdata[CB_MODE +: MODE_W],
                    rx_lsb:   reg_wdata[CB_RXORD],
                    tx_lsb:   reg_wdata[CB_TXORD]};

  assign start_pulse = wr_ctrl & ~busy_q & reg_wdata[CB_START] & mode_is_valid(cfg_wr.mode);

  always_comb begin
    cfg_d  = cfg_q;
    busy_d = busy_q;
    full_d = full_q;
    txd_d  = txd_q;
    rxb_d  = rxb_q;
    if (wr_ctrl && !busy_q) cfg_d = cfg_wr;
    if (wr_data && !busy_q) txd_d = reg_wdata;
    if (start_pulse) busy_d = 1'b1;
    if (rd_data) full_d = 1'b0;
    if (last) begin
      busy_d = 1'b0;
      full_d = 1'b1;
      rxb_d  = rx_next;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      cfg_q  <= '0;
      busy_q <= 1'b0;
      full_q <= 1'b0;
      txd_q  <= '0;
      rxb_q  <= '0;
    end else begin
      cfg_q  <= cfg_d;
      busy_q <= busy_d;
      full_q <= full_d;
      txd_q  <= txd_d;
      rxb_q  <= rxb_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr) begin
      reg_rdata = rxb_q;
    end else begin
      reg_rdata[CB_START]           = busy_q;
      reg_rdata[CB_TXORD]           = cfg_q.tx_lsb;
      reg_rdata[CB_RXORD]           = cfg_q.rx_lsb;
      reg_rdata[CB_MODE +: MODE_W]  = cfg_q.mode;
      reg_rdata[CB_EDGE]            = cfg_q.edge_sel;
      reg_rdata[CB_FULL]            = full_q;
    end
  end

  assign sck_oe = mode_is_master(cfg_q.mode);

  spi_eng_sck #(
    .SYNC_STAGES(SYNC_STAGES),
    .DIV_W      (DIV_W)
  ) u_sck (
    .clk     (clk),
    .rst_n   (srst_n),
    .busy    (busy_q),
    .cfg     (cfg_q),
    .idle_lvl(cfg_d.edge_sel),
    .sck_in  (sck_i),
    .sck_out (sck_o),
    .launch  (launch),
    .sample  (sample)
  );

  spi_eng_shift #(
    .DW(DW)
  ) u_shift (
    .clk     (clk),
    .rst_n   (srst_n),
    .load    (start_pulse),
    .load_val(txd_q),
    .launch  (launch),
    .sample  (sample),
    .tx_lsb  (cfg_q.tx_lsb),
    .rx_lsb  (cfg_q.rx_lsb),
    .sdi     (sdi),
    .sdo     (sdo),
    .last    (last),
    .rx_next (rx_next)
  );

endmodule

// File: rtl/spi_eng_chk.sv
module spi_eng_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       full,
  input logic [5:0] cfg,
  input logic       sck_o,
  input logic       sck_oe,
  input logic       sdo,
  input logic       reg_wr,
  input logic       reg_rd,
  input logic       reg_addr,
  input logic [5:0] wr_mode_start
);

  logic       edge_sel;
  logic [2:0] mode;
  assign edge_sel = cfg[5];
  assign mode     = cfg[4:2];

  // idle SCK level follows the edge select
  assert_sck_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sck_o == edge_sel));

  // data out only moves together with an SCK edge in master mode
  assert_sdo_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && mode <= 3'd4 && $stable(sck_o)) |-> $stable(sdo));

  // slave transfers neither drive nor move the local clock
  assert_slave_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mode == 3'd5) |-> (!sck_oe && $stable(sck_o)));

  // invalid code never starts a transfer
  assert_invalid_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_addr && !busy && wr_mode_start[0] && wr_mode_start[5:4] == 2'b11)
    |=> !busy);

  // completion raises the full flag (also when a read coincides, R9)
  assert_done_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> full);

  // read with no transfer running empties the buffer flag
  assert_read_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr && !busy) |=> !full);

  // configuration frozen during a transfer
  assert_cfg_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(cfg));

endmodule

bind spi_eng spi_eng_chk u_chk (
  .clk          (clk),
  .rst_n        (srst_n),
  .busy         (busy_q),
  .full         (full_q),
  .cfg          (cfg_q),
  .sck_o        (sck_o),
  .sck_oe       (sck_oe),
  .sdo          (sdo),
  .reg_wr       (reg_wr),
  .reg_rd       (reg_rd),
  .reg_addr     (reg_addr),
  .wr_mode_start(reg_wdata[5:0])
);

// File: tb/spi_eng_bench.sv
`timescale 1ns/1ps
module spi_eng_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0, reg_addr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       sck_i = 1'b0, sck_o, sck_oe, sdo;
  logic       loop_en = 1'b1, sdi_drv = 1'b0;
  logic       sdi;
  int         n_chk = 0, n_fail = 0, cyc = 0;

  always #2.5 clk = ~clk;
  assign sdi = loop_en ? sdo : sdi_drv;

  spi_eng u_spi_eng (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe), .sdo(sdo), .sdi(sdi)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic peek(input logic a, output logic [7:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic read_data(output logic [7:0] d);
    @(negedge clk); reg_addr = 1'b1; reg_rd = 1'b1; #1; d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic wait_idle();
    logic [7:0] c;
    for (int i = 0; i < 2000; i++) begin
      peek(1'b0, c);
      if (!c[0]) break;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    logic [7:0] v;
    peek(1'b0, v); check("R1 reset ctrl", v, 8'h00);
    peek(1'b1, v); check("R1 reset data", v, 8'h00);
    check("R7 reset sck idle low", {7'b0, sck_o}, 8'h00);
    check("R2 master drives sck", {7'b0, sck_oe}, 8'h01);
  endtask

  task automatic t_readback();
    logic [7:0] v;
    reg_write(1'b0, 8'h5E);
    peek(1'b0, v); check("R1 config readback", v, 8'h5E);
    check("R7 edge sel 1 idle high", {7'b0, sck_o}, 8'h01);
    reg_write(1'b0, 8'h80);
    peek(1'b0, v); check("R10 full bit not writable", v, 8'h00);
  endtask

  task automatic t_master(input string req, input logic [2:0] code, input logic ces,
                          input logic txl, input logic rxl,
                          input logic [7:0] tx, input logic [7:0] exp);
    logic [7:0] v;
    reg_write(1'b1, tx);
    reg_write(1'b0, {1'b0, ces, code, rxl, txl, 1'b1});
    peek(1'b0, v); check("R8 start bit busy", {7'b0, v[0]}, 8'h01);
    wait_idle();
    peek(1'b0, v); check("R8 full after done", {7'b0, v[7]}, 8'h01);
    read_data(v);  check(req, v, exp);
    peek(1'b0, v); check("R9 read clears full", {7'b0, v[7]}, 8'h00);
  endtask

  task automatic t_period(input logic [2:0] code);
    logic [7:0] v;
    int n;
    reg_write(1'b0, {2'b00, code, 3'b001});
    check("R2 sck_oe in master", {7'b0, sck_oe}, 8'h01);
    while (sck_o !== 1'b1) @(negedge clk);
    n = 0;
    while (sck_o !== 1'b0) begin @(negedge clk); n++; end
    while (sck_o !== 1'b1) begin @(negedge clk); n++; end
    check("R2 sck period", 8'(n), 8'(2 << code));
    wait_idle();
    read_data(v);
  endtask

  task automatic t_invalid(input logic [2:0] code);
    logic [7:0] v;
    logic s0;
    reg_write(1'b0, {2'b00, code, 3'b001});
    peek(1'b0, v); check("R4 invalid start ignored", v, {2'b00, code, 3'b000});
    s0 = sck_o; n_chk++;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (sck_o !== s0) begin
        n_fail++; $display("FAIL R4 sck toggled: actual %b expected %b", sck_o, s0); break;
      end
    end
    reg_write(1'b0, 8'h00);
  endtask

  task automatic t_busy_writes();
    logic [7:0] v;
    reg_write(1'b1, 8'h96);
    reg_write(1'b0, 8'h21);
    repeat (10) @(negedge clk);
    reg_write(1'b0, 8'h06);
    reg_write(1'b1, 8'hFF);
    peek(1'b0, v); check("R10 ctrl write ignored when busy", v, 8'h21);
    wait_idle();
    read_data(v); check("R10 data write ignored when busy", v, 8'h96);
    reg_write(1'b0, 8'h01);
    wait_idle();
    read_data(v); check("R10 tx data kept", v, 8'h96);
  endtask

  task automatic t_slave();
    logic [7:0] v, cap;
    logic [7:0] send = 8'h5A;
    loop_en = 1'b0;
    reg_write(1'b1, 8'hC3);
    reg_write(1'b0, 8'h2D);
    check("R3 slave releases sck", {7'b0, sck_oe}, 8'h00);
    cap = 8'h00;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); sck_i = 1'b1;
      repeat (6) @(negedge clk);
      cap = {cap[6:0], sdo};
      sdi_drv = send[i];
      repeat (2) @(negedge clk);
      sck_i = 1'b0;
      repeat (8) @(negedge clk);
    end
    check("R3 R5 slave tx msb first", cap, 8'hC3);
    wait_idle();
    read_data(v); check("R3 R6 slave rx lsb first", v, send);
    loop_en = 1'b1;
    reg_write(1'b0, 8'h00);
  endtask

  task automatic t_collide();
    logic [7:0] v, old;
    reg_write(1'b1, 8'h11);
    reg_write(1'b0, 8'h01);
    wait_idle();
    reg_write(1'b1, 8'h22);
    reg_write(1'b0, 8'h01);
    repeat (15) @(negedge clk);
    reg_addr = 1'b1; reg_rd = 1'b1; #1; old = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
    check("R9 read in done cycle sees old byte", old, 8'h11);
    peek(1'b0, v); check("R9 full kept on collision", {v[7], 6'b0, v[0]}, 8'h80);
    read_data(v); check("R9 R8 new byte buffered", v, 8'h22);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_readback();
    t_master("R5 msb out msb in", 3'd0, 1'b0, 1'b0, 1'b0, 8'hA5, 8'hA5);
    t_master("R5 R6 lsb out msb in", 3'd1, 1'b0, 1'b1, 1'b0, 8'h01, 8'h80);
    t_master("R6 msb out lsb in", 3'd0, 1'b0, 1'b0, 1'b1, 8'h01, 8'h80);
    t_master("R7 edge sel 1 transfer", 3'd2, 1'b1, 1'b1, 1'b1, 8'h3C, 8'h3C);
    t_period(3'd0);
    t_period(3'd2);
    t_period(3'd4);
    t_invalid(3'd6);
    t_invalid(3'd7);
    t_busy_writes();
    t_slave();
    t_collide();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule